// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Per-Entry Page Size

This block holds a small set of address translations and searches all of them at once. Each entry keeps a virtual page number, a context tag, a frame number, a lock bit and its own page size. The page size is one of four: 8 KB, 64 KB, 512 KB or 4 MB. A lookup compares the virtual address and context against every entry. In each entry's compare, the address bits that lie inside that entry's page are left out. One cycle later the block returns a hit flag, a flag for more than one match, and a 43-bit physical address. That address joins the entry's frame bits with the page-offset bits of the virtual address.

Entries are installed through a write port, and the block picks the slot. It takes the lowest free slot first. When no slot is free, a rotating pointer chooses among the unlocked entries, and locked entries are never evicted. A demap-all strobe flushes every unlocked entry and keeps the locked ones. Permission checks and table walking belong to the surrounding logic.

Top module: `xlat_fa_tlb`

## Requirements
- R1: After reset every entry is invalid. Every lookup then returns lk_hit=0, lk_multi=0 and lk_paddr=0, and wr_err is 0.
- R2: Lookup results are registered with one cycle of latency. They reflect the entries as they stood before the edge that captured the lookup, so a write or demap in the same cycle is not seen. When lk_en is low, the next cycle shows lk_hit=0 and lk_multi=0.
- R3: An entry matches when it is valid, its context equals lk_ctx, and the virtual page bits above its page offset are equal. The size code is wr_size: 00 gives 8 KB (13 offset bits), 01 gives 64 KB (16), 10 gives 512 KB (19) and 11 gives 4 MB (22).
- R4: On a hit, lk_paddr takes bits 42 down to the offset width from the matching entry's frame and the offset bits from lk_vaddr. Frame bits below the entry's offset are ignored. On a miss lk_paddr is 0.
- R5: Bits 46:43 of wr_frame are discarded. The translation is the same as if they were zero.
- R6: lk_multi is 1 when two or more entries match. The address then comes from the lowest-numbered matching slot, and lk_hit is also 1.
- R7: A write with at least one invalid slot fills the lowest-numbered invalid slot.
- R8: With every slot valid, a write replaces the first unlocked slot found by counting upward from a rotating pointer, wrapping around. The pointer is 0 after reset, moves to one past the replaced slot, and does not move when a free slot is used.
- R9: With every slot valid and locked, a write is refused, the contents stay unchanged, and wr_err is 1 in the following cycle only.
- R10: dm_all invalidates every valid unlocked entry. Locked entries keep translating.
- R11: When wr_en and dm_all occur together, the slot is chosen from the state before the flush, the flush is applied, and the new entry is installed valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_en | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Lookup virtual address |
| lk_ctx | input | 13 | Lookup context |
| lk_hit | output | 1 | Registered: at least one entry matched |
| lk_multi | output | 1 | Registered: two or more entries matched |
| lk_paddr | output | 43 | Registered physical address, 0 on miss |
| wr_en | input | 1 | Install request |
| wr_vaddr | input | 48 | Virtual address of the page to install |
| wr_ctx | input | 13 | Context of the new entry |
| wr_size | input | 2 | Page size code (see R3) |
| wr_lock | input | 1 | New entry is locked |
| wr_frame | input | 47 | Physical frame data; bits 46:43 ignored |
| wr_err | output | 1 | Registered: last write refused, all slots locked |
| dm_all | input | 1 | Flush all unlocked entries |

## Verification
Three functions can fall in one cycle: a lookup, a write and a flush. The bench drives a write and a lookup of the same page in one cycle and expects a miss, followed by a hit on the next lookup. It also pairs a flush with a write and expects the new entry to survive while the flushed ones miss. During the random phase all three strobes overlap freely. A behavioural model applies the ordering rule (lookup on the old state, victim chosen before the flush, then install) and is compared with the outputs on every clock.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // smallest page: 8 KB -> 13 offset bits; each size step adds 3 bits
  localparam int OFS_MIN = 13;
  localparam int SZ_STEP = 3;

  typedef enum logic [1:0] {
    PG_8K   = 2'b00,
    PG_64K  = 2'b01,
    PG_512K = 2'b10,
    PG_4M   = 2'b11
  } pg_size_e;
endpackage

// File: rtl/xlat_slot.sv
module xlat_slot
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W = 35,
  parameter int unsigned PFN_W = 30,
  parameter int unsigned CTX_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             flush,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic [CTX_W-1:0] ld_ctx,
  input  pg_size_e         ld_sz,
  input  logic             ld_lck,
  input  logic [PFN_W-1:0] ld_pfn,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [CTX_W-1:0] q_ctx,
  output logic             vld,
  output logic             lck,
  output logic             hit,
  output logic [PFN_W-1:0] pfn_mix
);
  logic             vld_q, vld_d;
  logic             lck_q, lck_d;
  logic [VPN_W-1:0] vpn_q;
  logic [CTX_W-1:0] ctx_q;
  pg_size_e         sz_q;
  logic [PFN_W-1:0] pfn_q;
  logic [VPN_W-1:0] keep;
  int               lowb;

  // control state: flush drops unlocked entries, a load overrides
  always_comb begin
    vld_d = vld_q;
    lck_d = lck_q;
    if (flush && !lck_q) vld_d = 1'b0;
    if (ld) begin
      vld_d = 1'b1;
      lck_d = ld_lck;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      lck_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      lck_q <= lck_d;
    end
  end

  // payload: loaded only on install, gated by vld_q everywhere
  always_ff @(posedge clk) begin
    if (ld) begin
      vpn_q <= ld_vpn;
      ctx_q <= ld_ctx;
      sz_q  <= ld_sz;
      pfn_q <= ld_pfn;
    end
  end

  // size-dependent compare mask and address merge
  always_comb begin
    lowb = SZ_STEP * int'(sz_q);
    for (int i = 0; i < int'(VPN_W); i++) keep[i] = (i >= lowb);
    for (int i = 0; i < int'(PFN_W); i++) pfn_mix[i] = (i < lowb) ? q_vpn[i] : pfn_q[i];
  end

  assign hit = vld_q && (ctx_q == q_ctx) && (((vpn_q ^ q_vpn) & keep) == '0);
  assign vld = vld_q;
  assign lck = lck_q;
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic [N-1:0]     vld,
  input  logic [N-1:0]     lck,
  input  logic [IDX_W-1:0] rr,
  output logic [IDX_W-1:0] idx,
  output logic             ok,
  output logic             via_free
);
  int j;

  always_comb begin
    idx      = '0;
    ok       = 1'b0;
    via_free = 1'b0;
    j        = 0;
    // lowest free slot: scan downward so the smallest index wins
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        idx      = IDX_W'(i);
        via_free = 1'b1;
      end
    end
    if (via_free) begin
      ok = 1'b1;
    end else begin
      // circular scan from rr, nearest unlocked slot wins
      for (int k = int'(N) - 1; k >= 0; k--) begin
        j = int'(rr) + k;
        if (j >= int'(N)) j = j - int'(N);
        if (!lck[j]) begin
          idx = IDX_W'(j);
          ok  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_merge.sv
module xlat_merge #(
  parameter int unsigned N     = 32,
  parameter int unsigned PFN_W = 30
) (
  input  logic [N-1:0]     hit,
  input  logic [PFN_W-1:0] pfn [N],
  output logic             any,
  output logic             many,
  output logic [PFN_W-1:0] pfn_sel
);
  int cnt;

  always_comb begin
    cnt     = 0;
    pfn_sel = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (hit[i]) pfn_sel = pfn[i];
    end
    for (int i = 0; i < int'(N); i++) cnt = cnt + int'(hit[i]);
  end

  assign any  = (cnt > 0);
  assign many = (cnt > 1);
endmodule

// File: rtl/xlat_fa_tlb.sv
module xlat_fa_tlb
  import xlat_pkg::*;
#(
  parameter int unsigned N_ENT = 32,
  parameter int unsigned VA_W  = 48,
  parameter int unsigned PA_W  = 43,
  parameter int unsigned CTX_W = 13,
  parameter int unsigned WD_W  = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [CTX_W-1:0]  lk_ctx,
  output logic              lk_hit,
  output logic              lk_multi,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              wr_en,
  input  logic [VA_W-1:0]   wr_vaddr,
  input  logic [CTX_W-1:0]  wr_ctx,
  input  logic [1:0]        wr_size,
  input  logic              wr_lock,
  input  logic [WD_W-1:0]   wr_frame,
  output logic              wr_err,
  input  logic              dm_all
);
  localparam int unsigned VPN_W = VA_W - OFS_MIN;
  localparam int unsigned PFN_W = PA_W - OFS_MIN;
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  logic [N_ENT-1:0] ent_vld, ent_lck, ent_hit;
  logic [PFN_W-1:0] ent_pfn [N_ENT];
  logic [IDX_W-1:0] vic_idx, rr_q, rr_d;
  logic             vic_ok, vic_free, wr_go;
  logic             any_hit, many_hit;
  logic [PFN_W-1:0] pfn_sel;
  logic             hit_d, multi_d, err_d;
  logic [PA_W-1:0]  pa_d;
  logic             unused_bits;

  assign unused_bits = ^{wr_frame[WD_W-1:PA_W], wr_frame[OFS_MIN-1:0], wr_vaddr[OFS_MIN-1:0]};

  xlat_pick #(.N(N_ENT), .IDX_W(IDX_W)) u_pick (
    .vld      (ent_vld),
    .lck      (ent_lck),
    .rr       (rr_q),
    .idx      (vic_idx),
    .ok       (vic_ok),
    .via_free (vic_free)
  );

  assign wr_go = wr_en && vic_ok;

  for (genvar g = 0; g < int'(N_ENT); g++) begin : g_slot
    xlat_slot #(.VPN_W(VPN_W), .PFN_W(PFN_W), .CTX_W(CTX_W)) u_slot (
      .clk     (clk),
      .rst_n   (arst_n),
      .ld      (wr_go && (vic_idx == IDX_W'(g))),
      .flush   (dm_all),
      .ld_vpn  (wr_vaddr[VA_W-1:OFS_MIN]),
      .ld_ctx  (wr_ctx),
      .ld_sz   (pg_size_e'(wr_size)),
      .ld_lck  (wr_lock),
      .ld_pfn  (wr_frame[PA_W-1:OFS_MIN]),
      .q_vpn   (lk_vaddr[VA_W-1:OFS_MIN]),
      .q_ctx   (lk_ctx),
      .vld     (ent_vld[g]),
      .lck     (ent_lck[g]),
      .hit     (ent_hit[g]),
      .pfn_mix (ent_pfn[g])
    );
  end

  xlat_merge #(.N(N_ENT), .PFN_W(PFN_W)) u_merge (
    .hit     (ent_hit),
    .pfn     (ent_pfn),
    .any     (any_hit),
    .many    (many_hit),
    .pfn_sel (pfn_sel)
  );

  // next state
  always_comb begin
    rr_d = rr_q;
    if (wr_go && !vic_free) begin
      rr_d = (vic_idx == IDX_W'(N_ENT - 1)) ? '0 : vic_idx + 1'b1;
    end
    err_d   = wr_en && !vic_ok;
    hit_d   = lk_en && any_hit;
    multi_d = lk_en && many_hit;
    pa_d    = hit_d ? {pfn_sel, lk_vaddr[OFS_MIN-1:0]} : '0;
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rr_q     <= '0;
      wr_err   <= 1'b0;
      lk_hit   <= 1'b0;
      lk_multi <= 1'b0;
      lk_paddr <= '0;
    end else begin
      rr_q     <= rr_d;
      wr_err   <= err_d;
      lk_hit   <= hit_d;
      lk_multi <= multi_d;
      lk_paddr <= pa_d;
    end
  end
endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
  parameter int unsigned N_ENT = 32,
  parameter int unsigned PA_W  = 43
) (
  input logic             clk,
  input logic             arst_n,
  input logic             lk_hit,
  input logic             lk_multi,
  input logic [PA_W-1:0]  lk_paddr,
  input logic             wr_en,
  input logic             wr_err,
  input logic             dm_all,
  input logic [N_ENT-1:0] ent_vld,
  input logic [N_ENT-1:0] ent_lck
);
  a_r6_multi_has_hit: assert property (@(posedge clk) disable iff (!arst_n)
    lk_multi |-> lk_hit);

  a_r4_miss_pa_zero: assert property (@(posedge clk) disable iff (!arst_n)
    !lk_hit |-> (lk_paddr == '0));

  a_r10_locked_survive: assert property (@(posedge clk) disable iff (!arst_n)
    1'b1 |=> (($past(ent_vld & ent_lck) & ~ent_vld) == '0));

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!arst_n)
    (dm_all && !wr_en) |=> ((ent_vld & ~ent_lck) == '0));

  a_r9_err_when_full: assert property (@(posedge clk) disable iff (!arst_n)
    wr_err |-> ($past(wr_en) && $past(&(ent_vld & ent_lck))));

  a_r9_err_no_change: assert property (@(posedge clk) disable iff (!arst_n)
    wr_err |-> ($stable(ent_vld) && $stable(ent_lck)));
endmodule

bind xlat_fa_tlb xlat_chk #(.N_ENT(N_ENT), .PA_W(PA_W)) u_chk (
  .clk      (clk),
  .arst_n   (arst_n),
  .lk_hit   (lk_hit),
  .lk_multi (lk_multi),
  .lk_paddr (lk_paddr),
  .wr_en    (wr_en),
  .wr_err   (wr_err),
  .dm_all   (dm_all),
  .ent_vld  (ent_vld),
  .ent_lck  (ent_lck)
);

// File: tb/test_xlat_fa_tlb.sv
`timescale 1ns/1ps
module test_xlat_fa_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_en = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic [12:0] lk_ctx = '0;
  logic        lk_hit, lk_multi, wr_err;
  logic [42:0] lk_paddr;
  logic        wr_en = 1'b0;
  logic [47:0] wr_vaddr = '0;
  logic [12:0] wr_ctx = '0;
  logic [1:0]  wr_size = '0;
  logic        wr_lock = 1'b0;
  logic [46:0] wr_frame = '0;
  logic        dm_all = 1'b0;

  int  n_chk = 0, n_err = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  xlat_fa_tlb i_xlat_fa_tlb (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_vaddr(lk_vaddr), .lk_ctx(lk_ctx),
    .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_paddr(lk_paddr),
    .wr_en(wr_en), .wr_vaddr(wr_vaddr), .wr_ctx(wr_ctx), .wr_size(wr_size),
    .wr_lock(wr_lock), .wr_frame(wr_frame), .wr_err(wr_err), .dm_all(dm_all)
  );

  // ---------------- behavioural reference ----------------
  bit              mv [32];
  bit              ml [32];
  int              msz [32];
  int              mctx [32];
  longint unsigned mvpn [32];
  longint unsigned mpfn [32];
  int              mrr = 0;
  bit              e_hit = 0, e_multi = 0, e_err = 0;
  longint unsigned e_pa = 0;

  function automatic bit m_match(int e, longint unsigned vpn, int ctx);
    return mv[e] && (mctx[e] == ctx) && (((mvpn[e] ^ vpn) >> (3 * msz[e])) == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mv[i]) begin mv[i] = 0; ml[i] = 0; end
      mrr = 0; e_hit = 0; e_multi = 0; e_err = 0; e_pa = 0;
    end else begin
      longint unsigned vpn, pfn, mix;
      int cnt, first, vic, lb;
      bit free_used;
      vpn = longint'(lk_vaddr) >> 13;
      cnt = 0; first = -1;
      for (int e = 0; e < 32; e++) begin
        if (m_match(e, vpn, int'(lk_ctx))) begin
          cnt++;
          if (first < 0) first = e;
        end
      end
      e_hit = lk_en && cnt > 0;
      e_multi = lk_en && cnt > 1;
      e_pa = 0;
      if (e_hit) begin
        lb = 3 * msz[first];
        pfn = mpfn[first];
        mix = ((pfn >> lb) << lb) | (vpn & ((64'd1 << lb) - 1));
        e_pa = ((mix << 13) | (longint'(lk_vaddr) & 64'h1fff)) & ((64'd1 << 43) - 1);
      end
      vic = -1; free_used = 0; e_err = 0;
      if (wr_en) begin
        for (int e = 31; e >= 0; e--) if (!mv[e]) vic = e;
        if (vic >= 0) free_used = 1;
        else begin
          for (int k = 0; k < 32; k++) begin
            if (vic < 0 && !ml[(mrr + k) % 32]) vic = (mrr + k) % 32;
          end
        end
        e_err = (vic < 0);
      end
      if (dm_all) foreach (mv[i]) if (!ml[i]) mv[i] = 0;
      if (vic >= 0) begin
        mv[vic] = 1; ml[vic] = wr_lock; msz[vic] = int'(wr_size);
        mctx[vic] = int'(wr_ctx);
        mvpn[vic] = longint'(wr_vaddr) >> 13;
        mpfn[vic] = (longint'(wr_frame) >> 13) & ((64'd1 << 30) - 1);
        if (!free_used) mrr = (vic + 1) % 32;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, longint unsigned got, longint unsigned exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R3 per-cycle hit", lk_hit, e_hit);
      chk("R6 per-cycle multi", lk_multi, e_multi);
      chk("R4 per-cycle paddr", lk_paddr, e_pa);
      chk("R9 per-cycle wr_err", wr_err, e_err);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge clk); #1;
    lk_en = 0; wr_en = 0; dm_all = 0; wr_lock = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step();
    rst_n = 1; step(); step(); step();
  endtask

  task automatic set_wr(logic [47:0] va, logic [12:0] c, logic [1:0] sz, logic lk, logic [46:0] fr);
    wr_en = 1; wr_vaddr = va; wr_ctx = c; wr_size = sz; wr_lock = lk; wr_frame = fr;
  endtask

  task automatic wr(logic [47:0] va, logic [12:0] c, logic [1:0] sz, logic lk, logic [46:0] fr);
    set_wr(va, c, sz, lk, fr); step();
  endtask

  task automatic look(string req, logic [47:0] va, logic [12:0] c, bit h, bit m, logic [42:0] pa);
    lk_en = 1; lk_vaddr = va; lk_ctx = c; step();
    chk({req, " hit"}, lk_hit, h);
    chk({req, " multi"}, lk_multi, m);
    chk({req, " paddr"}, lk_paddr, pa);
  endtask

  initial begin
    step();
    do_reset();
    // R1: empty after reset
    look("R1 empty", 48'h0000_0123_4000, 13'd7, 0, 0, 43'h0);
    chk("R1 wr_err idle", wr_err, 0);

    // R3/R4/R5: four page sizes
    wr(48'h0000_0123_4000, 13'd7, 2'b00, 0, 47'h0_0555_A000);
    wr(48'h0000_0456_0000, 13'd7, 2'b01, 0, {4'hF, 43'h123_4567_0000});
    wr(48'h0000_0788_0000, 13'd7, 2'b10, 0, 47'h0_0AA0_0000);
    wr(48'h0000_0C00_0000, 13'd7, 2'b11, 0, 47'h0_1241_5555);
    look("R4 8K", 48'h0000_0123_5ABC, 13'd7, 1, 0, 43'h0_0555_BABC);
    look("R3 8K next page", 48'h0000_0123_6000, 13'd7, 0, 0, 43'h0);
    look("R5 64K top bits", 48'h0000_0456_BEEF, 13'd7, 1, 0, 43'h123_4567_BEEF);
    look("R3 64K next page", 48'h0000_0457_0000, 13'd7, 0, 0, 43'h0);
    look("R3 context differs", 48'h0000_0456_BEEF, 13'd8, 0, 0, 43'h0);
    look("R4 512K", 48'h0000_078F_1234, 13'd7, 1, 0, 43'h0_0AA7_1234);
    look("R4 4M frame low bits ignored", 48'h0000_0C3A_BCDE, 13'd7, 1, 0, 43'h0_127A_BCDE);
    look("R3 4M next page", 48'h0000_0C40_0000, 13'd7, 0, 0, 43'h0);

    // R6: duplicate lands in a higher slot; lowest slot supplies the address
    wr(48'h0000_0456_0000, 13'd7, 2'b01, 0, 47'h0_0999_0000);
    look("R6 duplicate", 48'h0000_0456_0001, 13'd7, 1, 1, 43'h123_4567_0001);

    // R2: a same-cycle write is not visible to the lookup
    set_wr(48'h0000_0900_0000, 13'd7, 2'b00, 0, 47'h0_0333_0000);
    look("R2 same-cycle write", 48'h0000_0900_0010, 13'd7, 0, 0, 43'h0);
    look("R2 after write", 48'h0000_0900_0010, 13'd7, 1, 0, 43'h0_0333_0010);
    step();
    chk("R2 idle lookup hit", lk_hit, 0);

    // R11: flush and write together
    dm_all = 1;
    set_wr(48'h0000_1000_0000, 13'd7, 2'b00, 0, 47'h0_0777_0000);
    step();
    look("R11 new entry kept", 48'h0000_1000_0004, 13'd7, 1, 0, 43'h0_0777_0004);
    look("R11 old entry flushed", 48'h0000_0123_5ABC, 13'd7, 0, 0, 43'h0);

    // R9/R10: all slots locked
    do_reset();
    for (int i = 0; i < 32; i++) wr(48'(i + 1) << 13, 13'd3, 2'b00, 1, 47'(i) << 13);
    set_wr(48'h0000_0100_0000, 13'd3, 2'b00, 0, 47'h0_0111_0000);
    step();
    chk("R9 refused write flag", wr_err, 1);
    step();
    chk("R9 flag lasts one cycle", wr_err, 0);
    look("R9 refused entry absent", 48'h0000_0100_0000, 13'd3, 0, 0, 43'h0);
    dm_all = 1; step();
    look("R10 locked survives flush", 48'h0000_0000_2008, 13'd3, 1, 0, 43'h0_0000_0008);

    // R8: round robin skipping locked slots 0, 1, 5
    do_reset();
    for (int i = 0; i < 32; i++)
      wr(48'(i + 1) << 13, 13'd3, 2'b00, (i == 0 || i == 1 || i == 5), 47'(i + 64) << 13);
    wr(48'h0000_0200_0000, 13'd3, 2'b00, 0, 47'h0_0ABC_0000);
    look("R8 slot 2 replaced", 48'(3) << 13, 13'd3, 0, 0, 43'h0);
    look("R8 new entry", 48'h0000_0200_0000, 13'd3, 1, 0, 43'h0_0ABC_0000);
    wr(48'h0000_0200_2000, 13'd3, 2'b00, 0, 47'h0);
    wr(48'h0000_0200_4000, 13'd3, 2'b00, 0, 47'h0);
    wr(48'h0000_0200_6000, 13'd3, 2'b00, 0, 47'h0);
    look("R8 locked slot 5 kept", 48'(6) << 13, 13'd3, 1, 0, 43'(69) << 13);
    look("R8 slot 6 replaced", 48'(7) << 13, 13'd3, 0, 0, 43'h0);
    // R7: after flush, the lowest free slot (2) is below locked slot 5
    dm_all = 1; step();
    wr(48'(6) << 13, 13'd3, 2'b00, 0, 47'h0_0EEE_0000);
    look("R7 lowest free slot", 48'(6) << 13, 13'd3, 1, 1, 43'h0_0EEE_0000);

    // random mix, compared against the model every cycle
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 2 == 0) begin
        lk_en = 1;
        lk_vaddr = (48'($urandom % 4) << 22) | 48'($urandom & 32'h3F_FFFF);
        lk_ctx = 13'(1 + $urandom % 2);
      end
      if ($urandom % 3 == 0)
        set_wr((48'($urandom % 4) << 22) | 48'($urandom & 32'h3F_FFFF), 13'(1 + $urandom % 2),
               2'($urandom), ($urandom % 20 == 0), {15'($urandom), 32'($urandom)});
      if ($urandom % 40 == 0) dm_all = 1;
      step();
    end
    step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule